// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

The block sits beside a bus fabric and decides, for every access presented on one of its access ports, whether that access may proceed. A table of programmable region descriptors defines the address windows. Each descriptor holds a lower and an upper bound at 32-byte resolution, a rights nibble for every bus master, and an optional process-ID qualifier. All ports are checked in parallel against the whole table. An access is granted when any enabled descriptor covers its address, accepts its process ID and grants the requested kind of access to its master in its privilege mode. Rights from overlapping descriptors therefore add up.

Each port returns its verdict one cycle after the request. A denied access raises a one-cycle error flag. It also loads a per-port syndrome record with the address, master and access kind. The record keeps the first fault until software clears it. Descriptors are loaded through a plain write-only register port that takes a region index, a field selector and a 32-bit data word.

Top module: `mpu_region_chk`

## Requirements
- R1: After reset no descriptor is enabled, every syndrome record is empty and no result is flagged valid. Any access made before programming is denied.
- R2: A descriptor covers address A when A[31:5] lies between start[31:5] and end[31:5], both bounds included. The span therefore runs from start with its low 5 bits cleared up to end with its low 5 bits set. A descriptor whose start is above its end covers nothing.
- R3: When several enabled descriptors cover an address, the access is allowed if any one of them grants it.
- R4: A descriptor with its PID-check bit set grants only to accesses whose process ID equals its stored PID. With the bit clear, the process ID is ignored.
- R5: Each master m has a nibble at rights bits [4m+3:4m]. Bit 0 allows read (kind 0) and bit 1 allows write (kind 1), each independently of the other.
- R6: Execute (kind 2) can be granted only through bit 2 and only to processor masters, which are IDs 0 and 1. For other masters an execute is always denied. Kind 3 is always denied.
- R7: For a processor master in user mode (super = 0), a descriptor grants only if bit 3 of that master's nibble is set. Supervisor accesses, and accesses from non-processor masters, ignore bit 3.
- R8: A descriptor whose enable bit is clear never grants, whatever its bounds and rights.
- R9: chk_valid_o[p] is high in the cycle after acc_valid_i[p] was high, and low otherwise. chk_allow_o[p] and chk_err_o[p] are low when no result is valid.
- R10: chk_err_o[p] is high exactly when a valid result is a deny.
- R11: A deny on port p while its syndrome is empty loads syn_addr_o, syn_master_o and syn_type_o and sets syn_valid_o, in the same cycle as the error flag. Later faults leave the record unchanged until it is cleared.
- R12: syn_clr_i[p] empties the record on the next edge. If a deny happens in the same cycle as the clear, the record is loaded with that new fault instead.
- R13: The four ports are evaluated independently in the same cycle, each with its own master, address, kind, mode and process ID.
- R14: Configuration writes use cfg_sel_i to pick the field: 0 = start address, 1 = end address, 2 = rights word, 3 = control. The control word holds the enable in bit 0, the PID-check bit in bit 1 and the PID in bits [15:8]. A write takes effect for accesses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor field write strobe |
| cfg_idx_i | input | 4 | Descriptor index |
| cfg_sel_i | input | 2 | Field selector |
| cfg_wdata_i | input | 32 | Field write data |
| acc_valid_i | input | 4 | Per-port access request |
| acc_master_i | input | 4x2 | Per-port master ID |
| acc_addr_i | input | 4x32 | Per-port address |
| acc_type_i | input | 4x2 | Per-port kind: 0 read, 1 write, 2 execute |
| acc_super_i | input | 4 | Per-port supervisor mode |
| acc_pid_i | input | 4x8 | Per-port process ID |
| syn_clr_i | input | 4 | Per-port syndrome clear |
| chk_valid_o | output | 4 | Result valid |
| chk_allow_o | output | 4 | Access allowed |
| chk_err_o | output | 4 | Access denied, one-cycle error |
| syn_valid_o | output | 4 | Syndrome record holds a fault |
| syn_addr_o | output | 4x32 | Faulting address |
| syn_master_o | output | 4x2 | Faulting master |
| syn_type_o | output | 4x2 | Faulting access kind |

## Verification
Some properties are checked on every cycle by assertions:
- the one-cycle link from request to result;
- the error flag appearing only on a valid deny, together with a filled syndrome;
- the syndrome staying frozen while uncleared;
- execute always being refused to non-processor masters;
- control writes reaching the descriptor table.

The rights evaluation itself can only be shown by the bench's sweeps. These cover inclusive 32-byte bounds, the union of overlapping regions, the process-ID gate, the user-mode bit, disabled and inverted descriptors, and the first-fault and clear-versus-fault ordering of the syndrome.

// File: rtl/mpu_chk_pkg.sv
`timescale 1ns/1ps
package mpu_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam logic [1:0] CFG_START  = 2'd0;
  localparam logic [1:0] CFG_END    = 2'd1;
  localparam logic [1:0] CFG_RIGHTS = 2'd2;
  localparam logic [1:0] CFG_CTRL   = 2'd3;

  localparam int RIGHT_R = 0;
  localparam int RIGHT_W = 1;
  localparam int RIGHT_X = 2;
  localparam int RIGHT_U = 3;

  // nib: one master's rights; proc: master is a processor; sup: supervisor
  function automatic logic right_ok(logic [3:0] nib, logic [1:0] kind,
                                    logic proc, logic sup);
    logic ok;
    case (kind)
      ACC_READ:  ok = nib[RIGHT_R];
      ACC_WRITE: ok = nib[RIGHT_W];
      ACC_EXEC:  ok = proc & nib[RIGHT_X];
      default:   ok = 1'b0;
    endcase
    if (proc && !sup && !nib[RIGHT_U]) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/mpu_region_regs.sv
`timescale 1ns/1ps
module mpu_region_regs import mpu_chk_pkg::*; #(
  parameter int NR   = 16,
  parameter int AW   = 32,
  parameter int GB   = 5,
  parameter int NM   = 4,
  parameter int PW   = 8,
  parameter int DW   = 32,
  localparam int RW  = $clog2(NR),
  localparam int BW  = AW - GB,
  localparam int RTW = 4 * NM
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [RW-1:0]           cfg_idx_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic [DW-1:0]           cfg_wdata_i,
  output logic [NR-1:0][BW-1:0]   reg_start_o,
  output logic [NR-1:0][BW-1:0]   reg_end_o,
  output logic [NR-1:0][RTW-1:0]  reg_rights_o,
  output logic [NR-1:0]           reg_valid_o,
  output logic [NR-1:0]           reg_pid_en_o,
  output logic [NR-1:0][PW-1:0]   reg_pid_o
);

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_start_o  <= '0;
      reg_end_o    <= '0;
      reg_rights_o <= '0;
      reg_valid_o  <= '0;
      reg_pid_en_o <= '0;
      reg_pid_o    <= '0;
    end else if (cfg_we_i && (32'(cfg_idx_i) < NR)) begin
      case (cfg_sel_i)
        CFG_START:  reg_start_o[cfg_idx_i]  <= cfg_wdata_i[AW-1:GB];
        CFG_END:    reg_end_o[cfg_idx_i]    <= cfg_wdata_i[AW-1:GB];
        CFG_RIGHTS: reg_rights_o[cfg_idx_i] <= cfg_wdata_i[RTW-1:0];
        default: begin
          reg_valid_o[cfg_idx_i]  <= cfg_wdata_i[0];
          reg_pid_en_o[cfg_idx_i] <= cfg_wdata_i[1];
          reg_pid_o[cfg_idx_i]    <= cfg_wdata_i[8 +: PW];
        end
      endcase
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_sel_i == CFG_CTRL |=>
      reg_valid_o[$past(cfg_idx_i)] == $past(cfg_wdata_i[0])); // R14

endmodule

// File: rtl/mpu_region_match.sv
`timescale 1ns/1ps
module mpu_region_match import mpu_chk_pkg::*; #(
  parameter int NR   = 16,
  parameter int AW   = 32,
  parameter int GB   = 5,
  parameter int NM   = 4,
  parameter int NPM  = 2,
  parameter int PW   = 8,
  localparam int MW  = $clog2(NM),
  localparam int BW  = AW - GB,
  localparam int RTW = 4 * NM
) (
  input  logic [NR-1:0][BW-1:0]   reg_start_i,
  input  logic [NR-1:0][BW-1:0]   reg_end_i,
  input  logic [NR-1:0][RTW-1:0]  reg_rights_i,
  input  logic [NR-1:0]           reg_valid_i,
  input  logic [NR-1:0]           reg_pid_en_i,
  input  logic [NR-1:0][PW-1:0]   reg_pid_i,
  input  logic [MW-1:0]           acc_master_i,
  input  logic [BW-1:0]           acc_blk_i,
  input  logic [1:0]              acc_kind_i,
  input  logic                    acc_super_i,
  input  logic [PW-1:0]           acc_pid_i,
  output logic [NR-1:0]           grant_o
);

  logic is_proc;
  assign is_proc = 32'(acc_master_i) < NPM;

  for (genvar r = 0; r < NR; r++) begin : g_rgn
    logic       in_rng;
    logic       pid_ok;
    logic [3:0] nib;
    assign in_rng = (acc_blk_i >= reg_start_i[r]) && (acc_blk_i <= reg_end_i[r]);
    assign pid_ok = !reg_pid_en_i[r] || (reg_pid_i[r] == acc_pid_i);
    assign nib    = reg_rights_i[r][{acc_master_i, 2'b00} +: 4];
    assign grant_o[r] = reg_valid_i[r] & in_rng & pid_ok
                      & right_ok(nib, acc_kind_i, is_proc, acc_super_i);
  end

endmodule

// File: rtl/mpu_port_check.sv
`timescale 1ns/1ps
module mpu_port_check import mpu_chk_pkg::*; #(
  parameter int NR  = 16,
  parameter int AW  = 32,
  parameter int NM  = 4,
  parameter int NPM = 2,
  localparam int MW = $clog2(NM)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           acc_valid_i,
  input  logic [MW-1:0]  acc_master_i,
  input  logic [AW-1:0]  acc_addr_i,
  input  logic [1:0]     acc_kind_i,
  input  logic [NR-1:0]  grant_i,
  input  logic           syn_clr_i,
  output logic           chk_valid_o,
  output logic           chk_allow_o,
  output logic           chk_err_o,
  output logic           syn_valid_o,
  output logic [AW-1:0]  syn_addr_o,
  output logic [MW-1:0]  syn_master_o,
  output logic [1:0]     syn_type_o
);

  logic granted;
  logic deny;
  assign granted = |grant_i;
  assign deny    = acc_valid_i & ~granted;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_o  <= 1'b0;
      chk_allow_o  <= 1'b0;
      chk_err_o    <= 1'b0;
      syn_valid_o  <= 1'b0;
      syn_addr_o   <= '0;
      syn_master_o <= '0;
      syn_type_o   <= '0;
    end else begin
      chk_valid_o <= acc_valid_i;
      chk_allow_o <= acc_valid_i & granted;
      chk_err_o   <= deny;
      if (deny) begin
        syn_valid_o <= 1'b1;
        // first fault is kept; a clear in the same cycle lets the new fault in
        if (!syn_valid_o || syn_clr_i) begin
          syn_addr_o   <= acc_addr_i;
          syn_master_o <= acc_master_i;
          syn_type_o   <= acc_kind_i;
        end
      end else if (syn_clr_i) begin
        syn_valid_o <= 1'b0;
      end
    end
  end

  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> chk_valid_o); // R9
  AST_NO_RESULT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !chk_valid_o && !chk_allow_o && !chk_err_o); // R9
  AST_ERR_ON_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_err_o |-> chk_valid_o && !chk_allow_o && syn_valid_o); // R10
  AST_SYN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_valid_o && !syn_clr_i |=> syn_valid_o && $stable(syn_addr_o)
      && $stable(syn_master_o) && $stable(syn_type_o)); // R11
  AST_EXEC_PROC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_kind_i == ACC_EXEC && 32'(acc_master_i) >= NPM
      |=> !chk_allow_o && chk_err_o); // R6

endmodule

// File: rtl/mpu_region_chk.sv
`timescale 1ns/1ps
module mpu_region_chk import mpu_chk_pkg::*; #(
  parameter int NR   = 16,
  parameter int NP   = 4,
  parameter int AW   = 32,
  parameter int GB   = 5,
  parameter int NM   = 4,
  parameter int NPM  = 2,
  parameter int PW   = 8,
  parameter int DW   = 32,
  localparam int RW  = $clog2(NR),
  localparam int MW  = $clog2(NM),
  localparam int BW  = AW - GB,
  localparam int RTW = 4 * NM
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [RW-1:0]         cfg_idx_i,
  input  logic [1:0]            cfg_sel_i,
  input  logic [DW-1:0]         cfg_wdata_i,
  input  logic [NP-1:0]         acc_valid_i,
  input  logic [NP-1:0][MW-1:0] acc_master_i,
  input  logic [NP-1:0][AW-1:0] acc_addr_i,
  input  logic [NP-1:0][1:0]    acc_type_i,
  input  logic [NP-1:0]         acc_super_i,
  input  logic [NP-1:0][PW-1:0] acc_pid_i,
  input  logic [NP-1:0]         syn_clr_i,
  output logic [NP-1:0]         chk_valid_o,
  output logic [NP-1:0]         chk_allow_o,
  output logic [NP-1:0]         chk_err_o,
  output logic [NP-1:0]         syn_valid_o,
  output logic [NP-1:0][AW-1:0] syn_addr_o,
  output logic [NP-1:0][MW-1:0] syn_master_o,
  output logic [NP-1:0][1:0]    syn_type_o
);

  logic [NR-1:0][BW-1:0]  rg_start;
  logic [NR-1:0][BW-1:0]  rg_end;
  logic [NR-1:0][RTW-1:0] rg_rights;
  logic [NR-1:0]          rg_valid;
  logic [NR-1:0]          rg_pid_en;
  logic [NR-1:0][PW-1:0]  rg_pid;

  mpu_region_regs #(.NR(NR), .AW(AW), .GB(GB), .NM(NM), .PW(PW), .DW(DW)) regs_i (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_sel_i, .cfg_wdata_i,
    .reg_start_o(rg_start), .reg_end_o(rg_end), .reg_rights_o(rg_rights),
    .reg_valid_o(rg_valid), .reg_pid_en_o(rg_pid_en), .reg_pid_o(rg_pid)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [NR-1:0] grant;

    mpu_region_match #(.NR(NR), .AW(AW), .GB(GB), .NM(NM), .NPM(NPM), .PW(PW)) match_i (
      .reg_start_i(rg_start), .reg_end_i(rg_end), .reg_rights_i(rg_rights),
      .reg_valid_i(rg_valid), .reg_pid_en_i(rg_pid_en), .reg_pid_i(rg_pid),
      .acc_master_i(acc_master_i[p]), .acc_blk_i(acc_addr_i[p][AW-1:GB]),
      .acc_kind_i(acc_type_i[p]), .acc_super_i(acc_super_i[p]),
      .acc_pid_i(acc_pid_i[p]), .grant_o(grant)
    );

    mpu_port_check #(.NR(NR), .AW(AW), .NM(NM), .NPM(NPM)) port_i (
      .clk_i, .rst_ni,
      .acc_valid_i(acc_valid_i[p]), .acc_master_i(acc_master_i[p]),
      .acc_addr_i(acc_addr_i[p]), .acc_kind_i(acc_type_i[p]),
      .grant_i(grant), .syn_clr_i(syn_clr_i[p]),
      .chk_valid_o(chk_valid_o[p]), .chk_allow_o(chk_allow_o[p]),
      .chk_err_o(chk_err_o[p]), .syn_valid_o(syn_valid_o[p]),
      .syn_addr_o(syn_addr_o[p]), .syn_master_o(syn_master_o[p]),
      .syn_type_o(syn_type_o[p])
    );
  end

endmodule

// File: tb/mpu_region_chk_tb.sv
`timescale 1ns/1ps
module mpu_region_chk_tb_top;

  localparam int NP = 4;
  localparam int NR = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic                cfg_we = 1'b0;
  logic [3:0]          cfg_idx = '0;
  logic [1:0]          cfg_sel = '0;
  logic [31:0]         cfg_wdata = '0;
  logic [NP-1:0]       acc_valid = '0;
  logic [NP-1:0][1:0]  acc_master = '0;
  logic [NP-1:0][31:0] acc_addr = '0;
  logic [NP-1:0][1:0]  acc_type = '0;
  logic [NP-1:0]       acc_super = '0;
  logic [NP-1:0][7:0]  acc_pid = '0;
  logic [NP-1:0]       syn_clr = '0;
  logic [NP-1:0]       chk_valid, chk_allow, chk_err, syn_valid;
  logic [NP-1:0][31:0] syn_addr;
  logic [NP-1:0][1:0]  syn_master, syn_type;

  mpu_region_chk dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .acc_valid_i(acc_valid),
    .acc_master_i(acc_master), .acc_addr_i(acc_addr), .acc_type_i(acc_type),
    .acc_super_i(acc_super), .acc_pid_i(acc_pid), .syn_clr_i(syn_clr),
    .chk_valid_o(chk_valid), .chk_allow_o(chk_allow), .chk_err_o(chk_err),
    .syn_valid_o(syn_valid), .syn_addr_o(syn_addr), .syn_master_o(syn_master),
    .syn_type_o(syn_type)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_start [NR];
  logic [31:0] m_end   [NR];
  logic [31:0] m_rgt   [NR];
  logic [31:0] m_ctl   [NR];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected verdict derived from R2..R8
  function automatic bit exp_allow(int m, logic [31:0] a, int t, bit sup, logic [7:0] pid);
    for (int r = 0; r < NR; r++) begin
      bit cov, ok;
      logic [3:0] nib;
      cov = m_ctl[r][0] && (a[31:5] >= m_start[r][31:5]) && (a[31:5] <= m_end[r][31:5])
            && (!m_ctl[r][1] || m_ctl[r][15:8] == pid);
      nib = m_rgt[r][4*m +: 4];
      case (t)
        0: ok = nib[0];
        1: ok = nib[1];
        2: ok = (m < 2) && nib[2];
        default: ok = 1'b0;
      endcase
      if (m < 2 && !sup && !nib[3]) ok = 1'b0;
      if (cov && ok) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic cfg_wr(int idx, int sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      0: m_start[idx] = d;
      1: m_end[idx] = d;
      2: m_rgt[idx] = d;
      default: m_ctl[idx] = d;
    endcase
  endtask

  task automatic region(int idx, logic [31:0] s, logic [31:0] e, logic [31:0] rg, logic [31:0] c);
    cfg_wr(idx, 0, s); cfg_wr(idx, 1, e); cfg_wr(idx, 2, rg); cfg_wr(idx, 3, c);
  endtask

  logic [31:0] addrs [16] = '{32'h0FFF, 32'h1000, 32'h101F, 32'h107F, 32'h1080, 32'h10FF,
                             32'h1100, 32'h11FF, 32'h1200, 32'h2000, 32'h203F, 32'h2040,
                             32'h3000, 32'h3800, 32'h401F, 32'h4020};

  // all ports busy, each on a different address: R2 R3 R4 R5 R6 R7 R8 R13
  task automatic sweep(string tag);
    for (int ai = 0; ai < 16; ai++)
      for (int m = 0; m < 4; m++)
        for (int t = 0; t < 4; t++)
          for (int s = 0; s < 2; s++)
            for (int pi = 0; pi < 2; pi++) begin
              bit e [NP];
              for (int p = 0; p < NP; p++) begin
                acc_valid[p] = 1'b1;
                acc_master[p] = 2'((m + p) % 4);
                acc_addr[p] = addrs[(ai + 3 * p) % 16];
                acc_type[p] = 2'(t);
                acc_super[p] = 1'(s);
                acc_pid[p] = (pi ^ (p & 1)) ? 8'h5B : 8'h5A;
                e[p] = exp_allow((m + p) % 4, acc_addr[p], t, 1'(s), acc_pid[p]);
              end
              @(negedge clk);
              for (int p = 0; p < NP; p++)
                check(tag, {61'd0, chk_valid[p], chk_allow[p], chk_err[p]},
                      {61'd0, 1'b1, e[p], ~e[p]});
            end
    acc_valid = '0;
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_start[r] = '0; m_end[r] = '0; m_rgt[r] = '0; m_ctl[r] = '0;
    end
    repeat (3) @(negedge clk);
    check("R1 valid after reset", {60'd0, chk_valid}, 64'd0);
    check("R1 syndrome after reset", {60'd0, syn_valid}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: unprogrammed table denies everything
    for (int p = 0; p < NP; p++) begin
      acc_valid[p] = 1'b1; acc_master[p] = 2'(p); acc_addr[p] = 32'h1000 * p;
      acc_type[p] = 2'd0; acc_super[p] = 1'b1;
    end
    @(negedge clk);
    check("R1 deny before programming", {56'd0, chk_allow, chk_err}, {56'd0, 4'h0, 4'hF});
    acc_valid = '0;
    @(negedge clk);
    check("R9 idle gives no result", {60'd0, chk_valid}, 64'd0);
    syn_clr = '1;
    @(negedge clk);
    syn_clr = '0;
    check("R12 clear all", {60'd0, syn_valid}, 64'd0);

    // R14 programming through the field selector
    region(0,  32'h1000, 32'h10E0, 32'h0000_010B, 32'h1);
    region(1,  32'h1080, 32'h11E0, 32'h0000_00F6, 32'h1);
    region(2,  32'h2000, 32'h2020, 32'h0000_FFFF, 32'h5A03);
    region(3,  32'h3000, 32'h3FE0, 32'h0000_FFFF, 32'h0);
    region(4,  32'h3800, 32'h3000, 32'h0000_FFFF, 32'h1);
    region(15, 32'h4000, 32'h4000, 32'h0000_2400, 32'h1);
    sweep("R2/R3/R4/R5/R6/R7/R8/R13 sweep A");

    // R8 R14: disable region 0, enable region 3 without PID gate
    region(0, 32'h1000, 32'h10E0, 32'h0000_010B, 32'h0);
    region(3, 32'h3000, 32'h3FE0, 32'h0000_8C3B, 32'h1);
    sweep("R8/R14 sweep B");

    // syndrome sequence on port 1
    syn_clr = '1;
    @(negedge clk);
    syn_clr = '0;
    acc_valid = 4'b0010; acc_master[1] = 2'd1; acc_addr[1] = 32'h5004;
    acc_type[1] = 2'd0; acc_super[1] = 1'b1;
    @(negedge clk);
    check("R10 error on uncovered", {62'd0, chk_err[1], chk_allow[1]}, 64'd2);
    check("R11 syndrome addr", {32'd0, syn_addr[1]}, 64'h5004);
    check("R11 syndrome master/type", {59'd0, syn_valid[1], syn_master[1], syn_type[1]}, 64'b10100);
    check("R13 other ports untouched", {60'd0, syn_valid}, 64'b0010);
    acc_master[1] = 2'd2; acc_addr[1] = 32'h6008; acc_type[1] = 2'd1;
    @(negedge clk);
    check("R11 second fault ignored", {27'd0, syn_addr[1], syn_master[1], syn_type[1], chk_err[1]},
          {27'd0, 32'h5004, 2'd1, 2'd0, 1'b1});
    acc_master[1] = 2'd1; acc_addr[1] = 32'h1100; acc_type[1] = 2'd0;
    @(negedge clk);
    check("R10 allowed access no error", {62'd0, chk_allow[1], chk_err[1]}, 64'b10);
    acc_master[1] = 2'd3; acc_addr[1] = 32'h7010; acc_type[1] = 2'd2; syn_clr[1] = 1'b1;
    @(negedge clk);
    check("R12 clear with fault loads new", {27'd0, syn_addr[1], syn_master[1], syn_type[1], syn_valid[1]},
          {27'd0, 32'h7010, 2'd3, 2'd2, 1'b1});
    acc_valid = '0;
    @(negedge clk);
    syn_clr[1] = 1'b0;
    check("R12 clear empties record", {63'd0, syn_valid[1]}, 64'd0);
    check("R9 no result when idle", {60'd0, chk_valid}, 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule